// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block owns start-up and refresh for an asynchronous DRAM. After reset it waits out a fixed power-up pause. It then runs a burst of wake-up cycles and raises a ready flag. From then on it produces one refresh request per fixed interval. Each refresh is a CAS-before-RAS cycle. The memory supplies the row from its own counter, so the block drives no address and no data. It drives only the two strobes, and only while it owns the bus.

The block shares the memory pins with an access controller through a plain request/grant pair. The block raises `refresh_req` and waits. The controller finishes any access it has already started, then raises `refresh_gnt`. The controller must keep the grant high for as long as the request stays high. While it owns the bus, the block drives the strobes and asserts `strobe_oe`. After the precharge of each refresh cycle the block lowers its request for at least one clock, and the controller then takes the grant back. If refresh work is still owed, a new request follows.

Refreshes that wait for a grant are counted, up to a limit. If an interval expires while that count is already at the limit, the refresh deadline is taken as missed. Ready then drops, the owed refreshes are discarded, and the full wake-up sequence runs again.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is low, `ras_n` and `cas_n` are high, and `refresh_req`, `strobe_oe` and `mem_ready` are low.
- R2: After reset is released, the block waits PWR_CYC clocks. `refresh_req` first rises on clock PWR_CYC+1, counted from the release, and `mem_ready` stays low until then.
- R3: Between any fall of `mem_ready` (or reset) and the next rise, exactly WAKE_CNT refresh cycles take place. `mem_ready` rises on the clock that ends the precharge of the last of them.
- R4: In every refresh cycle, `cas_n` is low with `ras_n` high for CSR_CYC clocks before `ras_n` falls. `cas_n` stays low for CHR_CYC clocks after `ras_n` falls and is high again before `ras_n` rises. `ras_n` is low for RAS_CYC clocks. Both strobes are then high for PRE_CYC clocks while `strobe_oe` is still asserted.
- R5: A refresh cycle starts only on a clock where `refresh_req` and `refresh_gnt` were both high. An ungranted request is never withdrawn. `strobe_oe` is high only inside a granted cycle. With `strobe_oe` low both strobes are high, and the request is low on the clock after the strobes are released.
- R6: Once `mem_ready` is high, one refresh becomes due every REF_CYC clocks. When grants come at a fixed delay, consecutive `ras_n` falls are exactly REF_CYC clocks apart.
- R7: Up to PEND_MAX refreshes may wait for a grant, and none is dropped. At a point just before an interval ends, the number of refresh cycles since `mem_ready` rose equals the number of intervals that have elapsed.
- R8: An interval that ends while PEND_MAX refreshes are already waiting, with no refresh finishing on that clock, lowers `mem_ready`, discards the waiting refreshes and starts the wake-up sequence again. A refresh already under way completes and does not count toward the wake-up. Ending an interval and finishing a refresh on the same clock leaves the backlog unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| refresh_gnt | input | 1 | Bus granted by the access controller; held while `refresh_req` is high |
| refresh_req | output | 1 | Bus wanted for a refresh or wake-up cycle |
| ras_n | output | 1 | Row strobe, active low, meaningful while `strobe_oe` is high |
| cas_n | output | 1 | Column strobe (all byte lanes), active low |
| strobe_oe | output | 1 | Block is driving the strobes |
| mem_ready | output | 1 | Initialisation done and refresh deadline kept |

## Verification
Two events can land on the same clock: the end of a refresh interval, which adds one to the backlog, and the end of a refresh precharge, which takes one away. When they coincide the backlog must stay put, and a full backlog must not be mistaken for a missed deadline. The bench provokes this by drawing random grant delays over many intervals and by holding the grant off until the backlog reaches its limit, both short of an overrun and past it. It judges the outcome by the refresh count at points just before interval boundaries and by the level of `mem_ready`.

// File: rtl/dref_pkg.sv
package dref_pkg;

  typedef enum logic [1:0] {
    MODE_PAUSE = 2'd0,
    MODE_WAKE  = 2'd1,
    MODE_RUN   = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_REQ  = 3'd1,
    PH_CSU  = 3'd2,
    PH_CHR  = 3'd3,
    PH_RLO  = 3'd4,
    PH_PRE  = 3'd5
  } phase_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dref_interval.sv
// Interval timer: one tick every REF_CYC clocks while enabled (R6).
module dref_interval #(
  parameter int REF_CYC = 3900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(REF_CYC);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(REF_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dref_backlog.sv
// Saturating count of refreshes waiting for the bus (R7, R8).
module dref_backlog #(
  parameter int PEND_MAX = 4,
  localparam int BW = $clog2(PEND_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic          dec,
  output logic [BW-1:0] count,
  output logic          overrun
);
  logic full;

  assign full    = (count == BW'(PEND_MAX));
  assign overrun = inc && full && !dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  count <= '0;
    else if (clr)                count <= '0;
    else if (inc && !dec && !full) count <= count + 1'b1;
    else if (dec && !inc)        count <= count - 1'b1;
  end
endmodule

// File: rtl/dref_cbr_seq.sv
// One CAS-before-RAS cycle per grant: request, CAS setup, CAS hold,
// remaining RAS low time, precharge (R4, R5).
module dref_cbr_seq
  import dref_pkg::*;
#(
  parameter int CSR_CYC = 3,
  parameter int CHR_CYC = 3,
  parameter int RAS_CYC = 15,
  parameter int PRE_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic work,
  input  logic gnt,
  output logic req,
  output logic ras_n,
  output logic cas_n,
  output logic oe,
  output logic done
);
  localparam int RLO_CYC = RAS_CYC - CHR_CYC;
  localparam int LMAX    = max2(max2(CSR_CYC, CHR_CYC), max2(RLO_CYC, PRE_CYC));
  localparam int PW      = $clog2(LMAX + 1);

  phase_e        ph, ph_nx;
  logic [PW-1:0] pc, pc_nx;
  logic          last;

  assign last = (pc == '0);

  always_comb begin
    ph_nx = ph;
    pc_nx = last ? pc : pc - 1'b1;
    unique case (ph)
      PH_IDLE: if (work) ph_nx = PH_REQ;
      PH_REQ: if (gnt) begin
        ph_nx = PH_CSU;
        pc_nx = PW'(CSR_CYC - 1);
      end
      PH_CSU: if (last) begin
        ph_nx = PH_CHR;
        pc_nx = PW'(CHR_CYC - 1);
      end
      PH_CHR: if (last) begin
        if (RLO_CYC > 0) begin
          ph_nx = PH_RLO;
          pc_nx = PW'(RLO_CYC - 1);
        end else begin
          ph_nx = PH_PRE;
          pc_nx = PW'(PRE_CYC - 1);
        end
      end
      PH_RLO: if (last) begin
        ph_nx = PH_PRE;
        pc_nx = PW'(PRE_CYC - 1);
      end
      PH_PRE: if (last) ph_nx = PH_IDLE;
      default: ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE;
      pc <= '0;
    end else begin
      ph <= ph_nx;
      pc <= pc_nx;
    end
  end

  assign req   = (ph != PH_IDLE);
  assign oe    = (ph == PH_CSU) || (ph == PH_CHR) || (ph == PH_RLO) || (ph == PH_PRE);
  assign cas_n = !((ph == PH_CSU) || (ph == PH_CHR));
  assign ras_n = !((ph == PH_CHR) || (ph == PH_RLO));
  assign done  = (ph == PH_PRE) && last;
endmodule

// File: rtl/dram_refresh_sched.sv
// Power-up pause, wake-up burst and interval refresh for an async DRAM.
module dram_refresh_sched
  import dref_pkg::*;
#(
  parameter int PWR_CYC  = 50000,
  parameter int WAKE_CNT = 8,
  parameter int REF_CYC  = 3900,
  parameter int PEND_MAX = 4,
  parameter int CSR_CYC  = 3,
  parameter int CHR_CYC  = 3,
  parameter int RAS_CYC  = 15,
  parameter int PRE_CYC  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic refresh_gnt,
  output logic refresh_req,
  output logic ras_n,
  output logic cas_n,
  output logic strobe_oe,
  output logic mem_ready
);
  localparam int PAW = $clog2(PWR_CYC + 1);
  localparam int WW  = $clog2(WAKE_CNT + 1);
  localparam int BW  = $clog2(PEND_MAX + 1);

  mode_e          mode;
  logic [PAW-1:0] pause_cnt;
  logic [WW-1:0]  wake_left;
  logic           stale;
  logic           tick, overrun, seq_done, work;
  logic           wake_dec, run_dec;
  logic [BW-1:0]  backlog;

  // R8: a cycle in flight when the deadline is missed is not a wake-up cycle
  assign wake_dec = seq_done && (mode == MODE_WAKE) && !stale;
  assign run_dec  = seq_done && (mode == MODE_RUN);

  always_comb begin
    unique case (mode)
      MODE_WAKE: work = (wake_left != '0);
      MODE_RUN:  work = (backlog != '0);
      default:   work = 1'b0;
    endcase
  end

  dref_interval #(.REF_CYC(REF_CYC)) i_interval (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (mode == MODE_RUN),
    .tick (tick)
  );

  dref_backlog #(.PEND_MAX(PEND_MAX)) i_backlog (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (mode != MODE_RUN),
    .inc    (tick),
    .dec    (run_dec),
    .count  (backlog),
    .overrun(overrun)
  );

  dref_cbr_seq #(
    .CSR_CYC(CSR_CYC),
    .CHR_CYC(CHR_CYC),
    .RAS_CYC(RAS_CYC),
    .PRE_CYC(PRE_CYC)
  ) i_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .work (work),
    .gnt  (refresh_gnt),
    .req  (refresh_req),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .oe   (strobe_oe),
    .done (seq_done)
  );

  // R2, R3, R8: pause, wake-up burst, steady refresh, fall back on overrun
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= MODE_PAUSE;
      pause_cnt <= '0;
      wake_left <= '0;
      stale     <= 1'b0;
    end else begin
      if (overrun)       stale <= strobe_oe;
      else if (seq_done) stale <= 1'b0;

      unique case (mode)
        MODE_PAUSE: begin
          if (pause_cnt == PAW'(PWR_CYC - 1)) begin
            mode      <= MODE_WAKE;
            wake_left <= WW'(WAKE_CNT);
          end else begin
            pause_cnt <= pause_cnt + 1'b1;
          end
        end
        MODE_WAKE: begin
          if (wake_dec) begin
            wake_left <= wake_left - 1'b1;
            if (wake_left == WW'(1)) mode <= MODE_RUN;
          end
        end
        MODE_RUN: begin
          if (overrun) begin
            mode      <= MODE_WAKE;
            wake_left <= WW'(WAKE_CNT);
          end
        end
        default: mode <= MODE_PAUSE;
      endcase
    end
  end

  assign mem_ready = (mode == MODE_RUN);
endmodule

// File: rtl/dref_sched_chk.sv
module dref_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic refresh_gnt,
  input logic refresh_req,
  input logic ras_n,
  input logic cas_n,
  input logic strobe_oe,
  input logic mem_ready
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (ras_n && cas_n && !refresh_req && !strobe_oe && !mem_ready)
        else $error("R1 outputs active in reset");
    end
  end

  a_r5_pins_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_oe |-> (ras_n && cas_n));

  a_r5_start_granted: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_oe) |-> ($past(refresh_gnt) && $past(refresh_req)));

  a_r5_req_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !refresh_gnt) |=> refresh_req);

  a_r4_cas_leads: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  a_r4_cas_up_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n);

  a_r3_ready_released: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ready) |-> (!strobe_oe && !refresh_req));
endmodule

bind dram_refresh_sched dref_sched_chk i_chk (.*);

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
  localparam int PWR  = 40;
  localparam int WAKE = 8;
  localparam int REF  = 60;
  localparam int PMAX = 3;
  localparam int CSR  = 2;
  localparam int CHR  = 3;
  localparam int RASL = 6;
  localparam int PRE  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt = 1'b0;
  logic req, ras, cas, oe, ready;

  int total = 0, bad = 0;
  int idx = 0, ready_idx = 0, falls_run = 0, wake_falls = 0, last_fall = -1;
  int csu_run = 0, ras_low = 0, chr_run = 0, pre_run = 0;
  bit seen_req = 0, spacing_on = 0, hold_gnt = 0, rand_mode = 0;
  bit p_ras = 1, p_cas = 1, p_oe = 0, p_ready = 0;

  always #2 clk = ~clk;

  dram_refresh_sched #(
    .PWR_CYC(PWR), .WAKE_CNT(WAKE), .REF_CYC(REF), .PEND_MAX(PMAX),
    .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_CYC(RASL), .PRE_CYC(PRE)
  ) i_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .refresh_gnt(gnt), .refresh_req(req),
    .ras_n(ras), .cas_n(cas), .strobe_oe(oe), .mem_ready(ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int intervals_since(input int now, input int from);
    return (now - from) / REF;
  endfunction

  // access controller model: grants after a delay, holds while requested
  initial begin
    int waited = 0;
    int delay = 0;
    forever begin
      @(negedge clk);
      if (!req) begin
        gnt = 1'b0;
        waited = 0;
      end else if (!gnt && !hold_gnt) begin
        if (waited >= delay) begin
          gnt = 1'b1;
          delay = rand_mode ? int'($urandom_range(0, 8)) : 0;
        end else begin
          waited++;
        end
      end
    end
  end

  // monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (!rst_n) begin
        chk(ras && cas && !req && !oe && !ready, "R1 reset outputs", {ras, cas, req, oe, ready}, 5'b11000);
        continue;
      end
      idx++;
      if (!seen_req && req) begin
        seen_req = 1;
        chk(idx == PWR + 1, "R2 first request clock", idx, PWR + 1);
        chk(!ready, "R2 ready low in pause", ready, 0);
      end
      if (oe) chk(gnt, "R5 strobes without grant", gnt, 1);
      else    chk(ras && cas, "R5 strobes idle high", {ras, cas}, 2'b11);
      if (oe && ras && !cas) csu_run++;
      if (p_ras && !ras) begin
        chk(csu_run == CSR, "R4 CAS setup clocks", csu_run, CSR);
        chk(!cas, "R4 CAS low at RAS fall", cas, 0);
        csu_run = 0; ras_low = 0; chr_run = 0;
        if (ready) falls_run++; else wake_falls++;
        if (spacing_on && ready) begin
          if (last_fall >= 0) chk(idx - last_fall == REF, "R6 refresh spacing", idx - last_fall, REF);
          last_fall = idx;
        end
      end
      if (!ras) ras_low++;
      if (!ras && !cas) chr_run++;
      if (!p_cas && cas && !ras) chk(chr_run == CHR, "R4 CAS hold clocks", chr_run, CHR);
      if (!p_ras && ras) begin
        chk(ras_low == RASL, "R4 RAS low clocks", ras_low, RASL);
        chk(cas, "R4 CAS high at RAS rise", cas, 1);
        pre_run = 0;
      end
      if (oe && ras && cas) pre_run++;
      if (p_oe && !oe) begin
        chk(pre_run == PRE, "R4 precharge clocks", pre_run, PRE);
        chk(!req, "R5 request released", req, 0);
      end
      if (!p_ready && ready) begin
        chk(wake_falls == WAKE, "R3 wake-up cycle count", wake_falls, WAKE);
        ready_idx = idx;
        falls_run = 0;
      end
      if (p_ready && !ready) wake_falls = 0;
      p_ras = ras; p_cas = cas; p_oe = oe; p_ready = ready;
    end
  end

  task automatic to_boundary();
    do @(negedge clk);
    while (!(ready && idx > ready_idx && ((idx - ready_idx) % REF) == REF - 2));
  endtask

  task automatic count_check(input string tag);
    int exp;
    exp = intervals_since(idx, ready_idx);
    chk(falls_run == exp, tag, falls_run, exp);
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    bad++; total++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wait_ready();
    // R6: fixed grant delay gives exact spacing
    @(negedge clk); #1;
    spacing_on = 1; last_fall = -1;
    repeat (5 * REF) @(negedge clk);
    spacing_on = 0;
    to_boundary();
    count_check("R7 refreshes after spacing run");
    // R7: backlog up to the limit, no overrun
    #1 hold_gnt = 1;
    repeat (2 * REF + 10) @(negedge clk);
    chk(req, "R5 ungranted request kept", req, 1);
    chk(ready, "R8 no overrun at backlog limit", ready, 1);
    #1 hold_gnt = 0;
    to_boundary(); to_boundary();
    count_check("R7 backlog drained");
    // R8: deadline missed, wake-up repeated
    #1 hold_gnt = 1;
    repeat (5 * REF) @(negedge clk);
    chk(!ready, "R8 ready dropped on overrun", ready, 0);
    #1 hold_gnt = 0;
    wait_ready();
    chk(!oe, "R3 strobes released at ready", oe, 0);
    to_boundary(); to_boundary();
    count_check("R7 refreshes after re-wake");
    // R7/R8: random grant delays, tick and completion may coincide
    #1 rand_mode = 1;
    repeat (30 * REF) @(negedge clk);
    #1 rand_mode = 0;
    to_boundary(); to_boundary();
    count_check("R7 refreshes under random grants");
    chk(ready, "R8 ready kept under random grants", ready, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule